// File: doc/BRIEF.md
# Aligned Bitstream Header Sync Scanner

This block watches the opening bytes of a configuration bitstream as they stream past, one byte per valid beat, and decides whether the header carries the sync word in its byte-swapped form. A correct image is accepted only if the four sync bytes appear as a complete, word-aligned group inside a bounded header window. The scanner then gives a pass or fail verdict that loader logic can use before any image data is committed to the device.

A scan is armed by a start pulse, which also clears the byte position and any partly matched group. If the partial-reconfiguration bypass input is high with the start pulse, the check is skipped and the verdict is pass at once. In all other cases the verdict is given as early as it can be known: on the cycle after the last byte of an aligned matching group, after the last byte of the window, or after an end-of-stream pulse, whichever comes first. The verdict then holds until the next start.

Top module: `hdr_sync_scan`

## Requirements
- R1: A group matches only when its bytes arrive in the order 0x66, 0x55, 0x99, 0xAA. Any other order, or any byte that differs, is no match.
- R2: A match counts only when its first byte sits at a byte offset from the scan start that is a multiple of 4 (offset 0 is the first valid byte after start).
- R3: Only offsets 0 to 127 are examined. When byte 127 is consumed without a match, the cycle after it shows done_o=1, pass_o=0, and later bytes cannot produce a match.
- R4: A group of fewer than 4 bytes cut off by end of stream never matches, even when its bytes agree with the start of the sync word.
- R5: A scan that ends without an aligned match gives the verdict fail: done_o=1, pass_o=0, found_o=0. pass_o and found_o are only 1 when done_o is 1.
- R6: A start pulse with bypass_i=1 gives done_o=1, pass_o=1, found_o=0 on the next cycle, whatever bytes follow.
- R7: The cycle after the fourth byte of an aligned matching group is consumed shows done_o=1, pass_o=1, found_o=1. Before that cycle done_o is 0.
- R8: An eos_i pulse during a scan with no match gives done_o=1, pass_o=0 on the next cycle. A byte that is valid in the same cycle as eos_i is consumed first.
- R9: A start pulse resets the byte offset and the partial-group state. A byte that is valid in the same cycle as start_i is dropped.
- R10: A match whose last byte is byte 127 gives pass, not the window-exhausted fail.
- R11: Once done_o is 1, done_o, pass_o and found_o hold their values until the next start pulse, whatever bytes or eos_i pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; leaves the block scanning at offset 0 |
| start_i | input | 1 | Begin a new scan; clears offset and partial match |
| bypass_i | input | 1 | Sampled with start_i; 1 skips the check and gives pass |
| byte_i | input | 8 | Stream byte |
| valid_i | input | 1 | byte_i carries a stream byte this cycle |
| eos_i | input | 1 | End of stream; closes the scan |
| done_o | output | 1 | Verdict available |
| pass_o | output | 1 | Verdict: 1 pass, 0 fail (meaningful with done_o) |
| found_o | output | 1 | Pass came from an aligned sync match |

## Verification
Completing an aligned match and running out of the window can fall on the same byte, offset 127. The bench places the sync word at every aligned offset, including 124, and sends streams longer than the window. It expects pass at 124 and fail when the word starts at 128. A second collision is a start pulse that comes with a valid byte. The bench sends the first sync byte in that cycle and judges by the cycle in which the verdict appears whether the byte was dropped, as it must be.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic {
      ST_SCAN = 1'b0,
      ST_DONE = 1'b1
   } scan_state_e;

   typedef struct packed {
      logic done;
      logic pass;
      logic found;
   } verdict_t;
endpackage

// File: rtl/hss_pos_track.sv
module hss_pos_track #(
   parameter int WINDOW_BYTES = 128,
   parameter int GROUP_BYTES  = 4,
   localparam int NGROUPS = WINDOW_BYTES / GROUP_BYTES,
   localparam int LW      = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1,
   localparam int GW      = (NGROUPS > 1) ? $clog2(NGROUPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [LW-1:0] lane_o,
   output logic          lane_first_o,
   output logic          lane_last_o,
   output logic          win_last_o
);
   logic [GW-1:0] grp_q;
   logic          grp_last;

   generate
      if (GROUP_BYTES == 1) begin : g_single_lane
         assign lane_o       = '0;
         assign lane_first_o = 1'b1;
         assign lane_last_o  = 1'b1;
      end else begin : g_multi_lane
         logic [LW-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (clr_i)
               lane_q <= '0;
            else if (adv_i)
               lane_q <= (lane_q == LW'(GROUP_BYTES - 1)) ? '0 : lane_q + 1'b1;
         end
         assign lane_o       = lane_q;
         assign lane_first_o = (lane_q == '0);
         assign lane_last_o  = (lane_q == LW'(GROUP_BYTES - 1));
      end
   endgenerate

   generate
      if (NGROUPS == 1) begin : g_one_group
         assign grp_q    = '0;
         assign grp_last = 1'b1;
      end else begin : g_many_groups
         logic [GW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr_i)
               cnt_q <= '0;
            else if (adv_i && lane_last_o && (cnt_q != GW'(NGROUPS - 1)))
               cnt_q <= cnt_q + 1'b1;
         end
         assign grp_q    = cnt_q;
         assign grp_last = (cnt_q == GW'(NGROUPS - 1));
      end
   endgenerate

   assign win_last_o = grp_last && lane_last_o;
endmodule

// File: rtl/hss_group_match.sv
module hss_group_match #(
   parameter int GROUP_BYTES = 4,
   parameter logic [8*GROUP_BYTES-1:0] SYNC_WORD = 32'h6655_99AA,
   localparam int LW = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   input  logic [7:0]    byte_i,
   input  logic [LW-1:0] lane_i,
   input  logic          lane_first_i,
   input  logic          lane_last_i,
   output logic          group_hit_o
);
   logic [GROUP_BYTES-1:0] lane_eq;
   logic                   run_ok_q;
   logic                   byte_hit;
   logic                   run_next;

   // Lane k compares against the k-th byte of the word; first byte in the MSBs.
   generate
      for (genvar k = 0; k < GROUP_BYTES; k++) begin : g_lane_cmp
         assign lane_eq[k] = (byte_i == SYNC_WORD[8*(GROUP_BYTES-1-k) +: 8]);
      end
   endgenerate

   assign byte_hit    = lane_eq[lane_i];
   assign run_next    = byte_hit && (lane_first_i || run_ok_q);
   assign group_hit_o = adv_i && lane_last_i && run_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_ok_q <= 1'b0;
      else if (clr_i)
         run_ok_q <= 1'b0;
      else if (adv_i)
         run_ok_q <= run_next;
   end
endmodule

// File: rtl/hss_verdict.sv
module hss_verdict
   import hss_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic bypass_i,
   input  logic adv_i,
   input  logic group_hit_i,
   input  logic win_last_i,
   input  logic eos_i,
   output logic scanning_o,
   output logic done_o,
   output logic pass_o,
   output logic found_o
);
   scan_state_e state_q;
   verdict_t    vd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SCAN;
         vd_q    <= '0;
      end else if (start_i) begin
         if (bypass_i) begin
            state_q <= ST_DONE;
            vd_q    <= '{done: 1'b1, pass: 1'b1, found: 1'b0};
         end else begin
            state_q <= ST_SCAN;
            vd_q    <= '0;
         end
      end else if (state_q == ST_SCAN) begin
         // A match on the last window byte takes priority over exhaustion.
         if (group_hit_i) begin
            state_q <= ST_DONE;
            vd_q    <= '{done: 1'b1, pass: 1'b1, found: 1'b1};
         end else if ((adv_i && win_last_i) || eos_i) begin
            state_q <= ST_DONE;
            vd_q    <= '{done: 1'b1, pass: 1'b0, found: 1'b0};
         end
      end
   end

   assign scanning_o = (state_q == ST_SCAN);
   assign done_o     = vd_q.done;
   assign pass_o     = vd_q.pass;
   assign found_o    = vd_q.found;
endmodule

// File: rtl/hdr_sync_scan.sv
module hdr_sync_scan #(
   parameter int WINDOW_BYTES = 128,
   parameter int GROUP_BYTES  = 4,
   parameter logic [8*GROUP_BYTES-1:0] SYNC_WORD = 32'h6655_99AA,
   localparam int LW = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       bypass_i,
   input  logic [7:0] byte_i,
   input  logic       valid_i,
   input  logic       eos_i,
   output logic       done_o,
   output logic       pass_o,
   output logic       found_o
);
   generate
      if (GROUP_BYTES < 1) begin : g_bad_group
         $error("GROUP_BYTES must be at least 1");
      end
      if (WINDOW_BYTES < GROUP_BYTES) begin : g_bad_window
         $error("WINDOW_BYTES must hold at least one group");
      end
      if ((WINDOW_BYTES % GROUP_BYTES) != 0) begin : g_bad_multiple
         $error("WINDOW_BYTES must be a multiple of GROUP_BYTES");
      end
   endgenerate

   logic          scanning;
   logic          adv;
   logic [LW-1:0] lane;
   logic          lane_first;
   logic          lane_last;
   logic          win_last;
   logic          group_hit;

   assign adv = valid_i && scanning && !start_i;

   hss_pos_track #(
      .WINDOW_BYTES (WINDOW_BYTES),
      .GROUP_BYTES  (GROUP_BYTES)
   ) u_pos (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (start_i),
      .adv_i        (adv),
      .lane_o       (lane),
      .lane_first_o (lane_first),
      .lane_last_o  (lane_last),
      .win_last_o   (win_last)
   );

   hss_group_match #(
      .GROUP_BYTES (GROUP_BYTES),
      .SYNC_WORD   (SYNC_WORD)
   ) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (start_i),
      .adv_i        (adv),
      .byte_i       (byte_i),
      .lane_i       (lane),
      .lane_first_i (lane_first),
      .lane_last_i  (lane_last),
      .group_hit_o  (group_hit)
   );

   hss_verdict u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .bypass_i    (bypass_i),
      .adv_i       (adv),
      .group_hit_i (group_hit),
      .win_last_i  (win_last),
      .eos_i       (eos_i),
      .scanning_o  (scanning),
      .done_o      (done_o),
      .pass_o      (pass_o),
      .found_o     (found_o)
   );
endmodule

// File: rtl/hss_checker.sv
module hss_checker #(
   parameter int WINDOW_BYTES = 128,
   localparam int CW = $clog2(WINDOW_BYTES + 1)
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       bypass_i,
   input logic       valid_i,
   input logic       eos_i,
   input logic       done_o,
   input logic       pass_o,
   input logic       found_o
);
   logic [CW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (start_i)
         seen_q <= '0;
      else if (valid_i && !done_o && (seen_q != CW'(WINDOW_BYTES)))
         seen_q <= seen_q + 1'b1;
   end

   p_pass_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o);

   p_found_means_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> pass_o);

   p_bypass_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && bypass_i |=> done_o && pass_o && !found_o);

   p_start_rearms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !bypass_i |=> !done_o);

   p_verdict_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o && $stable(pass_o) && $stable(found_o));

   p_eos_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eos_i && !start_i |=> done_o);

   p_window_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == CW'(WINDOW_BYTES - 1)) && valid_i && !start_i && !done_o |=> done_o);
endmodule

bind hdr_sync_scan hss_checker #(.WINDOW_BYTES(WINDOW_BYTES)) u_hss_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .bypass_i (bypass_i),
   .valid_i  (valid_i),
   .eos_i    (eos_i),
   .done_o   (done_o),
   .pass_o   (pass_o),
   .found_o  (found_o)
);

// File: tb/hdr_sync_scan_bench.sv
module hdr_sync_scan_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       bypass_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       valid_i = 1'b0;
   logic       eos_i = 1'b0;
   logic       done_o, pass_o, found_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hdr_sync_scan u_hdr_sync_scan (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bypass_i(bypass_i),
      .byte_i(byte_i), .valid_i(valid_i), .eos_i(eos_i),
      .done_o(done_o), .pass_o(pass_o), .found_o(found_o)
   );

   function automatic logic [7:0] sync_byte(input int lane);
      case (lane)
         0: return 8'h66;
         1: return 8'h55;
         2: return 8'h99;
         default: return 8'hAA;
      endcase
   endfunction

   // Near-miss filler: lanes 0..2 agree with the word, lane 3 does not.
   function automatic logic [7:0] filler(input int k);
      return ((k % 4) == 3) ? 8'hA5 : sync_byte(k % 4);
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s done/pass/found actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cycle(input bit st, input bit bp, input bit v, input logic [7:0] b, input bit e);
      start_i = st; bypass_i = bp; valid_i = v; byte_i = b; eos_i = e;
      @(posedge clk);
      #1;
      start_i = 1'b0; bypass_i = 1'b0; valid_i = 1'b0; eos_i = 1'b0;
   endtask

   // Sync word at pos (negative: none), len bytes, optional eos pulse after.
   task automatic scan_case(input string req, input int pos, input int len, input bit send_eos);
      bit match;
      int done_idx;
      bit timing_ok;
      match = (pos >= 0) && (pos % 4 == 0) && (pos + 4 <= len) && (pos + 4 <= 128);
      done_idx = match ? pos + 3 : ((len >= 128) ? 127 : -1);
      timing_ok = 1'b1;
      cycle(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      for (int k = 0; k < len; k++) begin
         logic [7:0] b;
         bit exp_done;
         b = (pos >= 0 && k >= pos && k < pos + 4) ? sync_byte(k - pos) : filler(k);
         cycle(1'b0, 1'b0, 1'b1, b, 1'b0);
         exp_done = (done_idx >= 0) && (k >= done_idx);
         if (done_o !== exp_done) timing_ok = 1'b0;
      end
      if (send_eos) cycle(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      check({req, " timing"}, {timing_ok, 2'b00}, 3'b100);
      if (send_eos || done_idx >= 0)
         check(req, {done_o, pass_o, found_o}, {1'b1, match, match});
   endtask

   initial begin
      #1;
      @(posedge clk); #1;
      check("R5 reset", {done_o, pass_o, found_o}, 3'b000);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 R7 R10: every aligned offset, window 128 (R3 at 128).
      for (int p = 0; p <= 128; p += 4) begin
         string r;
         r = (p == 124) ? "R10" : ((p == 128) ? "R3" : "R7");
         scan_case(r, p, 136, 1'b0);
      end
      // R2: every unaligned offset inside the window.
      for (int p = 1; p < 128; p++) begin
         if (p % 4 != 0) scan_case("R2", p, 136, 1'b0);
      end
      // R3 R5: no word at all, window exhausts.
      scan_case("R3", -1, 140, 1'b0);
      // R8 R5: short stream without a word.
      scan_case("R8", -1, 21, 1'b1);
      // R4: truncated aligned group of 1, 2, 3 bytes.
      for (int t = 1; t <= 3; t++) scan_case("R4", 8, 8 + t, 1'b1);

      // R1: reversed order and a single wrong byte both fail.
      cycle(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h98, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      check("R1 no early verdict", {done_o, pass_o, found_o}, 3'b000);
      cycle(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      check("R1 wrong order", {done_o, pass_o, found_o}, 3'b100);

      // R8: eos in the same cycle as the completing byte: byte first.
      cycle(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b1);
      check("R8 byte with eos", {done_o, pass_o, found_o}, 3'b111);
      // R11: later eos, bytes and no start leave the verdict alone.
      cycle(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      cycle(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      check("R11 hold pass", {done_o, pass_o, found_o}, 3'b111);

      // R6: bypass gives pass without a match and ignores bytes.
      cycle(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
      check("R6 bypass", {done_o, pass_o, found_o}, 3'b110);
      cycle(1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
      check("R6 bypass held", {done_o, pass_o, found_o}, 3'b110);

      // R9: byte in the start cycle is dropped.
      cycle(1'b1, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      check("R9 start byte dropped", {done_o, pass_o, found_o}, 3'b000);
      cycle(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      check("R9 match after drop", {done_o, pass_o, found_o}, 3'b111);

      // R9: start mid-group clears partial match and offset.
      cycle(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      check("R9 partial cleared", {done_o, pass_o, found_o}, 3'b000);
      cycle(1'b0, 1'b0, 1'b1, 8'h66, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h55, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'h99, 1'b0);
      cycle(1'b0, 1'b0, 1'b1, 8'hAA, 1'b0);
      check("R9 offset restarted", {done_o, pass_o, found_o}, 3'b111);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule